// File: doc/BRIEF.md
# Tag-Matching Reservation Station Pool

This block holds instructions that have been dispatched but cannot yet execute. It has five station slots. Each slot is tied to one kind of functional unit: one integer ALU slot, one load slot, one store slot and two slots for a three-cycle floating-point unit. A dispatched instruction carries its class, an opcode, a destination tag and two source operands. The destination tag is the reorder-buffer index given to the instruction. Each source arrives either as a value with tag 0, or as a nonzero tag that names the reorder-buffer slot which will produce the value.

Every cycle the pool watches one result broadcast bus. A pending source whose tag equals the broadcast tag takes the broadcast value, and its tag becomes 0. A slot whose two tags are both 0 is ready. For each class, the ready slot with the lowest index is presented to that class's functional unit as an issue packet. A grant from the unit frees the slot at once. Tags name reorder-buffer slots, not station slots, so nothing waits for the result to come back before the slot is reused. A flush empties the whole pool.

Top module: `rs_pool`

## Requirements
- R1: Slot 0 serves class 0 (ALU), slot 1 class 1 (load), slot 2 class 2 (store), and slots 3 and 4 class 3 (floating point). `cls_full[c]` is high exactly when every slot of class c is busy.
- R2: A dispatch is ignored when its class is full or when flush is high in the same cycle. No slot changes and no packet appears as a result.
- R3: An accepted dispatch fills the lowest free slot of its class with its opcode, destination tag and operands. The slot becomes busy at the next clock edge. A source tag of 0 means the value that came with it is final.
- R4: When `bc_valid` is high and `bc_tag` equals a nonzero pending source tag of a busy slot, that slot takes `bc_value` into that operand and clears the tag. A broadcast with a different tag changes nothing.
- R5: If a dispatched source tag is nonzero and equals the broadcast tag in the same cycle, the operand is stored with `bc_value` and tag 0.
- R6: A slot is ready when it is busy and both source tags are 0. `iss_valid[c]` is high when some slot of class c is ready. The packet then shows the lowest-index ready slot of that class. Class c's fields sit at bits [c*W +: W] of `iss_op`, `iss_dest`, `iss_v1` and `iss_v2`.
- R7: `iss_grant[c]` while `iss_valid[c]` is high frees the presented slot at the next edge. A grant to a class with no ready slot has no effect.
- R8: A flush makes every slot not busy with tags cleared at the next edge. A later broadcast then produces no issue.
- R9: After reset every slot is free: `cls_full` and `iss_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the whole pool |
| disp_valid | input | 1 | Dispatch request |
| disp_class | input | 2 | Unit class of the dispatched instruction |
| disp_op | input | 4 | Opcode |
| disp_dest | input | 3 | Reorder-buffer index of the result |
| disp_src1_tag | input | 3 | Source 1 tag, 0 when value is final |
| disp_src1_val | input | 16 | Source 1 value |
| disp_src2_tag | input | 3 | Source 2 tag, 0 when value is final |
| disp_src2_val | input | 16 | Source 2 value |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | 3 | Broadcast reorder-buffer tag |
| bc_value | input | 16 | Broadcast result value |
| iss_grant | input | 4 | Per-class issue acceptance |
| cls_full | output | 4 | Per-class no-free-slot flags |
| iss_valid | output | 4 | Per-class ready packet present |
| iss_op | output | 16 | Per-class opcode, 4 bits each |
| iss_dest | output | 12 | Per-class destination tag, 3 bits each |
| iss_v1 | output | 64 | Per-class source 1 value, 16 bits each |
| iss_v2 | output | 64 | Per-class source 2 value, 16 bits each |

## Verification
Some properties are checked every cycle by the assertions:
- A flush leaves the pool empty.
- A dispatch to a full class never raises the occupancy.
- Occupancy grows by at most one slot per cycle.
- A granted packet always leaves its class with a free slot.
- A packet is only shown for a class that has a busy slot.

Other behaviour depends on values and ordering, and only the bench's scenarios show it:
- Which operand captured which broadcast value, across every tag and pending-operand mix.
- The capture when dispatch and broadcast happen in the same cycle.
- Lowest-index selection over age.
- That an ignored dispatch left the stored opcode untouched.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
    parameter int TAG_W   = 3;
    parameter int DATA_W  = 16;
    parameter int OP_W    = 4;
    parameter int NUM_ENT = 5;
    parameter int NUM_CLS = 4;
    localparam int CLS_W  = $clog2(NUM_CLS);

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [OP_W-1:0]   op_t;

    // class codes; a slot's class fixes which unit it feeds
    localparam int CLS_ALU   = 0;
    localparam int CLS_LOAD  = 1;
    localparam int CLS_STORE = 2;
    localparam int CLS_FP    = 3;

    typedef struct packed {
        logic  busy;
        op_t   op;
        tag_t  dest;
        tag_t  t1;
        tag_t  t2;
        data_t v1;
        data_t v2;
    } slot_t;

    function automatic int slot_class(int idx);
        case (idx)
            0:       return CLS_ALU;
            1:       return CLS_LOAD;
            2:       return CLS_STORE;
            default: return CLS_FP;
        endcase
    endfunction

    function automatic logic [NUM_ENT-1:0] class_mask(int cls);
        logic [NUM_ENT-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            m[i] = (slot_class(i) == cls);
        end
        return m;
    endfunction
endpackage

// File: rtl/rs_pick.sv
`timescale 1ns/1ps
module rs_pick #(
    parameter int W = 5
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < W; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_entry.sv
`timescale 1ns/1ps
module rs_entry
    import rs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush,
    input  logic  alloc,
    input  op_t   a_op,
    input  tag_t  a_dest,
    input  tag_t  a_t1,
    input  data_t a_v1,
    input  tag_t  a_t2,
    input  data_t a_v2,
    input  logic  bc_valid,
    input  tag_t  bc_tag,
    input  data_t bc_value,
    input  logic  release_i,
    output logic  busy_o,
    output logic  ready_o,
    output op_t   op_o,
    output tag_t  dest_o,
    output data_t v1_o,
    output data_t v2_o
);
    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.busy && bc_valid) begin
            if (slot_q.t1 != '0 && slot_q.t1 == bc_tag) begin
                slot_d.v1 = bc_value;
                slot_d.t1 = '0;
            end
            if (slot_q.t2 != '0 && slot_q.t2 == bc_tag) begin
                slot_d.v2 = bc_value;
                slot_d.t2 = '0;
            end
        end
        if (release_i) begin
            slot_d.busy = 1'b0;
        end
        if (alloc) begin
            slot_d.busy = 1'b1;
            slot_d.op   = a_op;
            slot_d.dest = a_dest;
            slot_d.t1   = a_t1;
            slot_d.v1   = a_v1;
            slot_d.t2   = a_t2;
            slot_d.v2   = a_v2;
        end
        if (flush) begin
            slot_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign busy_o  = slot_q.busy;
    assign ready_o = slot_q.busy && (slot_q.t1 == '0) && (slot_q.t2 == '0);
    assign op_o    = slot_q.op;
    assign dest_o  = slot_q.dest;
    assign v1_o    = slot_q.v1;
    assign v2_o    = slot_q.v2;
endmodule

// File: rtl/rs_pool.sv
`timescale 1ns/1ps
module rs_pool
    import rs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      disp_valid,
    input  logic [CLS_W-1:0]          disp_class,
    input  logic [OP_W-1:0]           disp_op,
    input  logic [TAG_W-1:0]          disp_dest,
    input  logic [TAG_W-1:0]          disp_src1_tag,
    input  logic [DATA_W-1:0]         disp_src1_val,
    input  logic [TAG_W-1:0]          disp_src2_tag,
    input  logic [DATA_W-1:0]         disp_src2_val,
    input  logic                      bc_valid,
    input  logic [TAG_W-1:0]          bc_tag,
    input  logic [DATA_W-1:0]         bc_value,
    input  logic [NUM_CLS-1:0]        iss_grant,
    output logic [NUM_CLS-1:0]        cls_full,
    output logic [NUM_CLS-1:0]        iss_valid,
    output logic [NUM_CLS*OP_W-1:0]   iss_op,
    output logic [NUM_CLS*TAG_W-1:0]  iss_dest,
    output logic [NUM_CLS*DATA_W-1:0] iss_v1,
    output logic [NUM_CLS*DATA_W-1:0] iss_v2
);
    logic [NUM_ENT-1:0] busy_q, ready, alloc, release_e;
    logic [NUM_ENT-1:0] free_oh [NUM_CLS];
    logic [NUM_ENT-1:0] pick_oh [NUM_CLS];
    op_t   e_op   [NUM_ENT];
    tag_t  e_dest [NUM_ENT];
    data_t e_v1   [NUM_ENT];
    data_t e_v2   [NUM_ENT];

    // operands resolved against a same-cycle broadcast
    tag_t  r_t1, r_t2;
    data_t r_v1, r_v2;

    always_comb begin
        r_t1 = disp_src1_tag;
        r_v1 = disp_src1_val;
        r_t2 = disp_src2_tag;
        r_v2 = disp_src2_val;
        if (bc_valid && disp_src1_tag != '0 && disp_src1_tag == bc_tag) begin
            r_t1 = '0;
            r_v1 = bc_value;
        end
        if (bc_valid && disp_src2_tag != '0 && disp_src2_tag == bc_tag) begin
            r_t2 = '0;
            r_v2 = bc_value;
        end
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        localparam logic [NUM_ENT-1:0] MASK = class_mask(c);

        rs_pick #(.W(NUM_ENT)) u_free_pick (
            .req (~busy_q & MASK),
            .gnt (free_oh[c])
        );
        rs_pick #(.W(NUM_ENT)) u_ready_pick (
            .req (ready & MASK),
            .gnt (pick_oh[c])
        );

        assign cls_full[c]  = ((busy_q & MASK) == MASK);
        assign iss_valid[c] = |pick_oh[c];

        always_comb begin
            iss_op  [c*OP_W   +: OP_W]   = '0;
            iss_dest[c*TAG_W  +: TAG_W]  = '0;
            iss_v1  [c*DATA_W +: DATA_W] = '0;
            iss_v2  [c*DATA_W +: DATA_W] = '0;
            for (int e = 0; e < NUM_ENT; e++) begin
                if (pick_oh[c][e]) begin
                    iss_op  [c*OP_W   +: OP_W]   = e_op[e];
                    iss_dest[c*TAG_W  +: TAG_W]  = e_dest[e];
                    iss_v1  [c*DATA_W +: DATA_W] = e_v1[e];
                    iss_v2  [c*DATA_W +: DATA_W] = e_v2[e];
                end
            end
        end
    end

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        localparam int EC = slot_class(e);

        assign alloc[e] = disp_valid && !flush
                       && (disp_class == CLS_W'(EC)) && free_oh[EC][e];
        assign release_e[e] = pick_oh[EC][e] && iss_grant[EC];

        rs_entry u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .alloc     (alloc[e]),
            .a_op      (disp_op),
            .a_dest    (disp_dest),
            .a_t1      (r_t1),
            .a_v1      (r_v1),
            .a_t2      (r_t2),
            .a_v2      (r_v2),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_value  (bc_value),
            .release_i (release_e[e]),
            .busy_o    (busy_q[e]),
            .ready_o   (ready[e]),
            .op_o      (e_op[e]),
            .dest_o    (e_dest[e]),
            .v1_o      (e_v1[e]),
            .v2_o      (e_v2[e])
        );
    end
endmodule

// File: rtl/rs_pool_chk.sv
`timescale 1ns/1ps
module rs_pool_chk
    import rs_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               disp_valid,
    input logic [CLS_W-1:0]   disp_class,
    input logic [NUM_CLS-1:0] iss_grant,
    input logic [NUM_CLS-1:0] cls_full,
    input logic [NUM_CLS-1:0] iss_valid,
    input logic [NUM_ENT-1:0] busy
);
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cls_full == '0 && iss_valid == '0)); // R8

    AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !flush && cls_full[disp_class])
        |=> ($countones(busy) <= $past($countones(busy)))); // R2

    AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> ($countones(busy) <= $past($countones(busy)) + 1)); // R3

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_chk
        localparam logic [NUM_ENT-1:0] MASK = class_mask(c);

        AST_GRANT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid[c] && iss_grant[c] && !flush) |=> !cls_full[c]); // R7

        AST_ISS_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[c] |-> ((busy & MASK) != '0)); // R6
    end
endmodule

bind rs_pool rs_pool_chk u_rs_pool_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .disp_valid (disp_valid),
    .disp_class (disp_class),
    .iss_grant  (iss_grant),
    .cls_full   (cls_full),
    .iss_valid  (iss_valid),
    .busy       (busy_q)
);

// File: tb/rs_pool_bench.sv
`timescale 1ns/1ps
module rs_pool_bench;
    import rs_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic disp_valid = 1'b0;
    logic [CLS_W-1:0]  disp_class = '0;
    logic [OP_W-1:0]   disp_op = '0;
    logic [TAG_W-1:0]  disp_dest = '0, disp_src1_tag = '0, disp_src2_tag = '0;
    logic [DATA_W-1:0] disp_src1_val = '0, disp_src2_val = '0;
    logic bc_valid = 1'b0;
    logic [TAG_W-1:0]  bc_tag = '0;
    logic [DATA_W-1:0] bc_value = '0;
    logic [NUM_CLS-1:0] iss_grant = '0;
    logic [NUM_CLS-1:0] cls_full, iss_valid;
    logic [NUM_CLS*OP_W-1:0]   iss_op;
    logic [NUM_CLS*TAG_W-1:0]  iss_dest;
    logic [NUM_CLS*DATA_W-1:0] iss_v1, iss_v2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rs_pool u_rs_pool (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_class(disp_class), .disp_op(disp_op),
        .disp_dest(disp_dest), .disp_src1_tag(disp_src1_tag),
        .disp_src1_val(disp_src1_val), .disp_src2_tag(disp_src2_tag),
        .disp_src2_val(disp_src2_val), .bc_valid(bc_valid), .bc_tag(bc_tag),
        .bc_value(bc_value), .iss_grant(iss_grant), .cls_full(cls_full),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dest(iss_dest),
        .iss_v1(iss_v1), .iss_v2(iss_v2)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int op_of(int c);  return int'(iss_op[c*OP_W +: OP_W]); endfunction
    function automatic int dst_of(int c); return int'(iss_dest[c*TAG_W +: TAG_W]); endfunction
    function automatic int v1_of(int c);  return int'(iss_v1[c*DATA_W +: DATA_W]); endfunction
    function automatic int v2_of(int c);  return int'(iss_v2[c*DATA_W +: DATA_W]); endfunction

    // called at a negedge; applies stimulus for one edge, returns at next negedge
    task automatic tick();
        @(negedge clk);
        disp_valid = 1'b0;
        bc_valid   = 1'b0;
        iss_grant  = '0;
        flush      = 1'b0;
    endtask

    task automatic set_disp(int cls, int op, int dest, int t1, int v1, int t2, int v2);
        disp_valid    = 1'b1;
        disp_class    = CLS_W'(cls);
        disp_op       = OP_W'(op);
        disp_dest     = TAG_W'(dest);
        disp_src1_tag = TAG_W'(t1);
        disp_src1_val = DATA_W'(v1);
        disp_src2_tag = TAG_W'(t2);
        disp_src2_val = DATA_W'(v2);
    endtask

    task automatic set_bc(int tag, int val);
        bc_valid = 1'b1;
        bc_tag   = TAG_W'(tag);
        bc_value = DATA_W'(val);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", "cls_full in reset", int'(cls_full), 0);
        check("R9", "iss_valid in reset", int'(iss_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "cls_full after reset", int'(cls_full), 0);
        check("R9", "iss_valid after reset", int'(iss_valid), 0);

        // R3 R6 R7: one ready instruction per class
        for (int c = 0; c < NUM_CLS; c++) begin
            set_disp(c, c + 1, c + 1, 0, 100 + c, 0, 200 + c);
            tick();
            check("R6", "iss_valid single", int'(iss_valid), 1 << c);
            check("R3", "op", op_of(c), c + 1);
            check("R3", "dest", dst_of(c), c + 1);
            check("R3", "v1", v1_of(c), 100 + c);
            check("R3", "v2", v2_of(c), 200 + c);
            check("R1", "full one busy", int'(cls_full), (c == CLS_FP) ? 0 : (1 << c));
            iss_grant = NUM_CLS'(1 << c);
            tick();
            check("R7", "freed iss_valid", int'(iss_valid), 0);
            check("R7", "freed cls_full", int'(cls_full), 0);
        end

        // R1 R2: fill every class with pending work on tag 7
        begin
            int expfull;
            expfull = 0;
            for (int e = 0; e < NUM_ENT; e++) begin
                set_disp(slot_class(e), e + 1, e + 1, 7, 0, 0, 40 + e);
                tick();
                expfull |= (slot_class(e) == CLS_FP) ? ((e == NUM_ENT - 1) ? 8 : 0)
                                                     : (1 << slot_class(e));
                check("R1", "cls_full while filling", int'(cls_full), expfull);
            end
        end
        check("R1", "all full", int'(cls_full), 4'hF);
        for (int c = 0; c < NUM_CLS; c++) begin
            set_disp(c, 15, 6, 0, 999, 0, 999);
            tick();
            check("R2", "full dispatch no issue", int'(iss_valid), 0);
        end
        iss_grant = 4'hF;
        tick();
        check("R7", "grant without ready ignored", int'(cls_full), 4'hF);
        set_bc(7, 16'h55);
        tick();
        check("R4", "all ready after broadcast", int'(iss_valid), 4'hF);
        for (int c = 0; c < NUM_CLS; c++) begin
            check("R2", "original op kept", op_of(c), c + 1);
            check("R4", "captured v1", v1_of(c), 16'h55);
            check("R4", "v2 kept", v2_of(c), 40 + c);
        end
        iss_grant = 4'h8;
        tick();
        check("R6", "second FP slot next", op_of(CLS_FP), 5);
        check("R7", "FP not full after issue", int'(cls_full[CLS_FP]), 0);
        flush = 1'b1;
        tick();
        check("R8", "flush cls_full", int'(cls_full), 0);
        check("R8", "flush iss_valid", int'(iss_valid), 0);

        // R8: broadcast after flush wakes nothing
        set_disp(CLS_ALU, 3, 2, 5, 0, 0, 1);
        tick();
        flush = 1'b1;
        tick();
        set_bc(5, 77);
        tick();
        check("R8", "no wake after flush", int'(iss_valid), 0);

        // R2: dispatch in a flush cycle is ignored
        set_disp(CLS_LOAD, 9, 3, 0, 1, 0, 2);
        flush = 1'b1;
        tick();
        check("R2", "dispatch with flush", int'(iss_valid), 0);
        check("R2", "dispatch with flush full", int'(cls_full), 0);

        // R4: capture sweep over tags and pending-operand mixes
        for (int tag = 1; tag < 8; tag++) begin
            for (int mode = 1; mode < 4; mode++) begin
                int val;
                val = tag * 17 + mode;
                set_disp(CLS_ALU, mode, tag, (mode & 1) ? tag : 0, tag * 3,
                         (mode & 2) ? tag : 0, tag * 5);
                tick();
                set_bc((tag % 7) + 1, 16'hBAD);
                tick();
                check("R4", "other tag no wake", int'(iss_valid[CLS_ALU]), 0);
                set_bc(tag, val);
                tick();
                check("R4", "wake on match", int'(iss_valid[CLS_ALU]), 1);
                check("R4", "sweep v1", v1_of(CLS_ALU), (mode & 1) ? val : tag * 3);
                check("R4", "sweep v2", v2_of(CLS_ALU), (mode & 2) ? val : tag * 5);
                iss_grant = 4'h1;
                tick();
            end
        end

        // R5: dispatch and broadcast in the same cycle
        for (int tag = 1; tag < 8; tag++) begin
            set_disp(CLS_LOAD, 2, tag, tag, 0, 0, 9);
            set_bc(tag, tag * 11);
            tick();
            check("R5", "same-cycle ready", int'(iss_valid[CLS_LOAD]), 1);
            check("R5", "same-cycle v1", v1_of(CLS_LOAD), tag * 11);
            check("R5", "same-cycle v2", v2_of(CLS_LOAD), 9);
            iss_grant = 4'h2;
            tick();
        end
        set_disp(CLS_LOAD, 2, 1, 3, 0, 0, 9);
        set_bc(4, 123);
        tick();
        check("R5", "same-cycle other tag waits", int'(iss_valid[CLS_LOAD]), 0);
        flush = 1'b1;
        tick();

        // R6: lowest index wins, not oldest
        set_disp(CLS_FP, 6, 1, 3, 0, 0, 60);
        tick();
        set_disp(CLS_FP, 7, 2, 0, 70, 0, 71);
        tick();
        check("R6", "only ready slot shown", op_of(CLS_FP), 7);
        set_bc(3, 33);
        tick();
        check("R6", "lowest index first", op_of(CLS_FP), 6);
        check("R6", "lowest index dest", dst_of(CLS_FP), 1);
        iss_grant = 4'h8;
        tick();
        check("R6", "then higher index", op_of(CLS_FP), 7);
        iss_grant = 4'h8;
        tick();
        check("R7", "FP empty", int'(iss_valid[CLS_FP]), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule